// File: doc/BRIEF.md
# Variable-Length Bitstream Store Packer

This unit sits beside a processor's load/store path. It accepts codes of variable length, such as entropy-coder output, and turns them into a gapless stream of bits in memory. Each command from the decode stage carries a code value and its length in bits. The unit appends the code to a 32-bit accumulator, most significant free bit first. When the accumulator fills, it emits the completed word as a single memory write and advances its own write address by one word.

A flush command closes the stream. It pads the unused low bits of the partial word with ones and writes that word out if it holds any bits. Software can read and overwrite the write address, the partial word, the bit count and a sticky error flag through a small special-purpose register port. This lets it start a new stream, save and restore a stream, or recover after a bad command.

The command shares its opcode with the double-word store. When the packer is disabled, a command is still accepted and retires as a no-operation, so decode never has to raise an illegal-instruction trap for it. The unit holds one outstanding memory write. New commands are stalled until that write has been taken.

Top module: `vlc_packer`

## Requirements
- R1: Codes of 1 to 16 bits are packed MSB-first with no gaps. The first code fills the most significant free bit positions of the current word. Code bits above the given length are ignored. The partial word keeps its unused low bits at zero.
- R2: When a code completes a 32-bit word, that word is written to memory at the current write address, and the address advances by 4. Any leftover code bits start the next word. If a code fills the word exactly, the bit count becomes 0 and the partial word becomes 0.
- R3: An emitted word stays on the memory write port, with stable address and data, until `mem_wready` is high. While it is pending, `cmd_ready` is low, so no command is taken or lost.
- R4: A flush ORs ones into the unused low bits of the partial word, writes that word if the bit count is non-zero, and then clears the bit count and the partial word. A flush with a count of 0 produces no write.
- R5: A code command with length 0 or greater than 16 changes neither the stream nor the address and produces no write. It sets the sticky error flag.
- R6: While `pk_enable` is low, commands are accepted (`cmd_ready` high) but change no state, write nothing and leave the error flag alone.
- R7: The register port selects by `spr_sel` as follows: 0 = write address, 1 = partial word, 2 = bit count (0..31), 3 = status (bit 0 = error flag). Reads are combinational. Writing the address forces its two low bits to zero and clears the bit count. Writing status loads the error flag from bit 0.
- R8: During a cycle with `spr_we` high, `cmd_ready` is low.
- R9: After reset, the write address, partial word, bit count and error flag are 0, `mem_wvalid` is low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pk_enable | input | 1 | Packer enable; when low, commands retire as no-ops |
| cmd_valid | input | 1 | Command present from decode |
| cmd_flush | input | 1 | 1 = flush command, 0 = code command |
| cmd_code | input | 16 | Code value, right-aligned |
| cmd_len | input | 5 | Code length in bits (valid range 1..16) |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| mem_wvalid | output | 1 | Word write request |
| mem_waddr | output | 32 | Byte address of the word write |
| mem_wdata | output | 32 | Word to write |
| mem_wready | input | 1 | Memory takes the write |
| spr_we | input | 1 | Register write strobe |
| spr_sel | input | 2 | Register select |
| spr_wdata | input | 32 | Register write data |
| spr_rdata | output | 32 | Register read data for spr_sel |

## Verification
The packing is driven through a table of commands chosen to separate the cases: codes that stay inside one word, a code that lands the count on 31, a code that straddles the boundary by one bit, and two 16-bit codes that fill a word exactly. Codes with junk above their length show whether masking is applied. Flushes are issued with and without pending bits, to separate the padded write from the case with no write at all. Further commands cover illegal lengths, the disabled mode, register writes that leave a partial word with dirty low bits, and a memory that withholds ready for several cycles while a command waits.

// File: rtl/vlcp_pkg.sv
package vlcp_pkg;

  typedef enum logic [1:0] {
    REG_WADDR  = 2'd0,
    REG_PART   = 2'd1,
    REG_COUNT  = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/vlcp_merge.sv
module vlcp_merge #(
  parameter int WORD_W = 32,
  parameter int CODE_W = 16,
  parameter int CNT_W  = 5,
  parameter int LEN_W  = 5
) (
  input  logic [WORD_W-1:0] acc_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              full_o,
  output logic [WORD_W-1:0] emit_word_o,
  output logic [WORD_W-1:0] rem_word_o,
  output logic [CNT_W-1:0]  next_cnt_o,
  output logic [WORD_W-1:0] flush_word_o
);

  localparam int WIN_W = 2 * WORD_W;
  localparam int SUM_W = $clog2(WIN_W) + 1;

  logic [CODE_W-1:0] code_mask;
  logic [CODE_W-1:0] code_clean;
  logic [WORD_W-1:0] low_fill;
  logic [WORD_W-1:0] acc_clean;
  logic [SUM_W-1:0]  total;
  logic [SUM_W-1:0]  shamt;
  logic [WIN_W-1:0]  code_win;
  logic [WIN_W-1:0]  win;

  // one mask bit per code bit: kept when its index is below the length
  generate
    for (genvar b = 0; b < CODE_W; b++) begin : g_mask
      assign code_mask[b] = (SUM_W'(b) < SUM_W'(len_i));
    end
  endgenerate

  always_comb begin
    total      = SUM_W'(cnt_i) + SUM_W'(len_i);
    shamt      = SUM_W'(WIN_W) - total;
    low_fill   = {WORD_W{1'b1}} >> cnt_i;
    acc_clean  = acc_i & ~low_fill;
    code_clean = code_i & code_mask;
    code_win   = {{(WIN_W-CODE_W){1'b0}}, code_clean} << shamt;
    win        = {acc_clean, {WORD_W{1'b0}}} | code_win;
    full_o     = (total >= SUM_W'(WORD_W));
    emit_word_o = win[WIN_W-1:WORD_W];
    if (full_o) begin
      rem_word_o = win[WORD_W-1:0];
      next_cnt_o = CNT_W'(total - SUM_W'(WORD_W));
    end else begin
      rem_word_o = win[WIN_W-1:WORD_W];
      next_cnt_o = CNT_W'(total);
    end
    flush_word_o = acc_clean | low_fill;
  end

endmodule

// File: rtl/vlcp_wbuf.sv
module vlcp_wbuf #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_addr_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              mem_wready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] addr_o,
  output logic [WORD_W-1:0] data_o
);

  logic              valid_q, valid_d;
  logic [WORD_W-1:0] addr_q, data_q;
  logic              cap_en;

  always_comb begin
    valid_d = valid_q;
    if (valid_q && mem_wready_i) valid_d = 1'b0;
    if (load_i)                  valid_d = 1'b1;
    cap_en = load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (cap_en) begin
        addr_q <= load_addr_i;
        data_q <= load_data_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !valid_q); // R3

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !mem_wready_i) |=> (valid_q && $stable(addr_q) && $stable(data_q))); // R3

endmodule

// File: rtl/vlcp_state.sv
module vlcp_state
  import vlcp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spr_we_i,
  input  logic [1:0]        spr_sel_i,
  input  logic [WORD_W-1:0] spr_wdata_i,
  input  logic              code_take_i,
  input  logic [WORD_W-1:0] code_rem_i,
  input  logic [CNT_W-1:0]  code_cnt_i,
  input  logic              flush_take_i,
  input  logic              err_take_i,
  input  logic              emit_i,
  output logic [WORD_W-1:0] addr_o,
  output logic [WORD_W-1:0] acc_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              err_o,
  output logic [WORD_W-1:0] rdata_o
);

  localparam int ADDR_LSB = $clog2(WORD_W / 8);
  localparam logic [WORD_W-1:0] ADDR_STEP = WORD_W'(WORD_W / 8);

  reg_sel_e          sel;
  logic [WORD_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              err_q, err_d;

  assign sel = reg_sel_e'(spr_sel_i);

  always_comb begin
    addr_d = addr_q;
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    err_d  = err_q;
    if (spr_we_i) begin
      unique case (sel)
        REG_WADDR: begin
          addr_d = {spr_wdata_i[WORD_W-1:ADDR_LSB], {ADDR_LSB{1'b0}}};
          cnt_d  = '0;
        end
        REG_PART:   acc_d = spr_wdata_i;
        REG_COUNT:  cnt_d = spr_wdata_i[CNT_W-1:0];
        REG_STATUS: err_d = spr_wdata_i[0];
        default: ;
      endcase
    end else begin
      if (code_take_i) begin
        acc_d = code_rem_i;
        cnt_d = code_cnt_i;
      end
      if (flush_take_i) begin
        acc_d = '0;
        cnt_d = '0;
      end
      if (err_take_i) err_d = 1'b1;
      if (emit_i)     addr_d = addr_q + ADDR_STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    unique case (sel)
      REG_WADDR:  rdata_o = addr_q;
      REG_PART:   rdata_o = acc_q;
      REG_COUNT:  rdata_o = WORD_W'(cnt_q);
      REG_STATUS: rdata_o = WORD_W'(err_q);
      default:    rdata_o = '0;
    endcase
  end

  assign addr_o = addr_q;
  assign acc_o  = acc_q;
  assign cnt_o  = cnt_q;
  assign err_o  = err_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_i && !spr_we_i) |=> (addr_q == $past(addr_q) + ADDR_STEP)); // R2

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_take_i && !spr_we_i) |=> (cnt_q == '0)); // R4

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(err_take_i || (spr_we_i && sel == REG_STATUS))); // R5

  AST_ADDR_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_we_i && sel == REG_WADDR) |=> (cnt_q == '0 && addr_q[ADDR_LSB-1:0] == '0)); // R7

endmodule

// File: rtl/vlc_packer.sv
module vlc_packer #(
  parameter int WORD_W = 32,
  parameter int CODE_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pk_enable,
  input  logic                         cmd_valid,
  input  logic                         cmd_flush,
  input  logic [CODE_W-1:0]            cmd_code,
  input  logic [$clog2(CODE_W):0]      cmd_len,
  output logic                         cmd_ready,
  output logic                         mem_wvalid,
  output logic [WORD_W-1:0]            mem_waddr,
  output logic [WORD_W-1:0]            mem_wdata,
  input  logic                         mem_wready,
  input  logic                         spr_we,
  input  logic [1:0]                   spr_sel,
  input  logic [WORD_W-1:0]            spr_wdata,
  output logic [WORD_W-1:0]            spr_rdata
);

  localparam int LEN_W = $clog2(CODE_W) + 1;
  localparam int CNT_W = $clog2(WORD_W);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  logic [WORD_W-1:0] addr_q, acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q;
  logic              full;
  logic [WORD_W-1:0] emit_word, rem_word, flush_word;
  logic [CNT_W-1:0]  next_cnt;
  logic              accept, len_bad;
  logic              code_take, flush_take, err_take, emit;
  logic [WORD_W-1:0] load_data;

  vlcp_merge #(
    .WORD_W(WORD_W), .CODE_W(CODE_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_merge (
    .acc_i       (acc_q),
    .cnt_i       (cnt_q),
    .code_i      (cmd_code),
    .len_i       (cmd_len),
    .full_o      (full),
    .emit_word_o (emit_word),
    .rem_word_o  (rem_word),
    .next_cnt_o  (next_cnt),
    .flush_word_o(flush_word)
  );

  always_comb begin
    cmd_ready  = !mem_wvalid && !spr_we;
    accept     = cmd_valid && cmd_ready;
    len_bad    = (cmd_len == '0) || (cmd_len > LEN_W'(CODE_W));
    code_take  = accept && pk_enable && !cmd_flush && !len_bad;
    err_take   = accept && pk_enable && !cmd_flush && len_bad;
    flush_take = accept && pk_enable && cmd_flush;
    emit       = (code_take && full) || (flush_take && (cnt_q != '0));
    load_data  = cmd_flush ? flush_word : emit_word;
  end

  vlcp_state #(
    .WORD_W(WORD_W), .CNT_W(CNT_W)
  ) u_state (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .spr_we_i    (spr_we),
    .spr_sel_i   (spr_sel),
    .spr_wdata_i (spr_wdata),
    .code_take_i (code_take),
    .code_rem_i  (rem_word),
    .code_cnt_i  (next_cnt),
    .flush_take_i(flush_take),
    .err_take_i  (err_take),
    .emit_i      (emit),
    .addr_o      (addr_q),
    .acc_o       (acc_q),
    .cnt_o       (cnt_q),
    .err_o       (err_q),
    .rdata_o     (spr_rdata)
  );

  vlcp_wbuf #(
    .WORD_W(WORD_W)
  ) u_wbuf (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .load_i      (emit),
    .load_addr_i (addr_q),
    .load_data_i (load_data),
    .mem_wready_i(mem_wready),
    .valid_o     (mem_wvalid),
    .addr_o      (mem_waddr),
    .data_o      (mem_wdata)
  );

  AST_DISABLED_NOP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cmd_valid && cmd_ready && !pk_enable) |=>
      (!mem_wvalid && $stable(cnt_q) && $stable(acc_q) && $stable(addr_q) && $stable(err_q))); // R6

  AST_BAD_LEN_NOP: assert property (@(posedge clk) disable iff (!rst_core_n)
    err_take |=> (!mem_wvalid && $stable(cnt_q) && $stable(acc_q) && err_q)); // R5

endmodule

// File: tb/tb_vlc_packer.sv
module tb_vlc_packer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pk_enable, cmd_valid, cmd_flush;
  logic [15:0] cmd_code;
  logic [4:0]  cmd_len;
  logic        cmd_ready, mem_wvalid, mem_wready;
  logic [31:0] mem_waddr, mem_wdata;
  logic        spr_we;
  logic [1:0]  spr_sel;
  logic [31:0] spr_wdata, spr_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vlc_packer dut (
    .clk(clk), .rst_n(rst_n), .pk_enable(pk_enable),
    .cmd_valid(cmd_valid), .cmd_flush(cmd_flush), .cmd_code(cmd_code), .cmd_len(cmd_len),
    .cmd_ready(cmd_ready), .mem_wvalid(mem_wvalid), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_wready(mem_wready), .spr_we(spr_we),
    .spr_sel(spr_sel), .spr_wdata(spr_wdata), .spr_rdata(spr_rdata)
  );

  typedef struct packed {
    logic        fl;
    logic [15:0] code;
    logic [4:0]  len;
    logic        emit;
    logic [31:0] addr;
    logic [31:0] data;
    logic [4:0]  cnt;
    logic [31:0] part;
    logic        err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h0005, 5'd3,  1'b0, 32'h0,   32'h0,        5'd3,  32'hA0000000, 1'b0},
    '{1'b0, 16'hFABC, 5'd12, 1'b0, 32'h0,   32'h0,        5'd15, 32'hB5780000, 1'b0},
    '{1'b0, 16'h1234, 5'd16, 1'b0, 32'h0,   32'h0,        5'd31, 32'hB5782468, 1'b0},
    '{1'b0, 16'h0003, 5'd2,  1'b1, 32'h100, 32'hB5782469, 5'd1,  32'h80000000, 1'b0},
    '{1'b1, 16'h0000, 5'd0,  1'b1, 32'h104, 32'hFFFFFFFF, 5'd0,  32'h00000000, 1'b0},
    '{1'b1, 16'h0000, 5'd0,  1'b0, 32'h0,   32'h0,        5'd0,  32'h00000000, 1'b0},
    '{1'b0, 16'hFFFF, 5'd0,  1'b0, 32'h0,   32'h0,        5'd0,  32'h00000000, 1'b1},
    '{1'b0, 16'hFFFF, 5'd17, 1'b0, 32'h0,   32'h0,        5'd0,  32'h00000000, 1'b1},
    '{1'b0, 16'h00FF, 5'd16, 1'b0, 32'h0,   32'h0,        5'd16, 32'h00FF0000, 1'b1},
    '{1'b0, 16'h00FF, 5'd16, 1'b1, 32'h108, 32'h00FF00FF, 5'd0,  32'h00000000, 1'b1},
    '{1'b0, 16'hFF01, 5'd4,  1'b0, 32'h0,   32'h0,        5'd4,  32'h10000000, 1'b1},
    '{1'b0, 16'h8001, 5'd1,  1'b0, 32'h0,   32'h0,        5'd5,  32'h18000000, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    spr_sel = s;
    #1;
    v = spr_rdata;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    spr_we = 1'b1; spr_sel = s; spr_wdata = d;
    @(negedge clk);
    spr_we = 1'b0;
  endtask

  // presents one command and returns at the falling edge after it was taken
  task automatic send(input logic f, input logic [15:0] c, input logic [4:0] l);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_flush = f; cmd_code = c; cmd_len = l;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; pk_enable = 1'b1; cmd_valid = 1'b0; cmd_flush = 1'b0;
    cmd_code = '0; cmd_len = '0; mem_wready = 1'b1; spr_we = 1'b0;
    spr_sel = '0; spr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 reset state
    chk("R9", "cmd_ready", {31'b0, cmd_ready}, 32'd1);
    chk("R9", "mem_wvalid", {31'b0, mem_wvalid}, 32'd0);
    rd(2'd0, v); chk("R9", "address", v, 32'h0);
    rd(2'd1, v); chk("R9", "partial", v, 32'h0);
    rd(2'd2, v); chk("R9", "count", v, 32'h0);
    rd(2'd3, v); chk("R9", "status", v, 32'h0);

    wr(2'd0, 32'h100);

    // table walk: R1 packing, R2 emission, R4 flush, R5 bad lengths
    for (int i = 0; i < NV; i++) begin
      send(VEC[i].fl, VEC[i].code, VEC[i].len);
      chk("R2", "write strobe", {31'b0, mem_wvalid}, {31'b0, VEC[i].emit});
      if (VEC[i].emit) begin
        chk(VEC[i].fl ? "R4" : "R2", "write addr", mem_waddr, VEC[i].addr);
        chk(VEC[i].fl ? "R4" : "R2", "write data", mem_wdata, VEC[i].data);
      end
      rd(2'd2, v); chk(VEC[i].fl ? "R4" : "R1", "count", v, {27'b0, VEC[i].cnt});
      rd(2'd1, v); chk(VEC[i].fl ? "R4" : "R1", "partial", v, VEC[i].part);
      rd(2'd3, v); chk("R5", "error flag", v, {31'b0, VEC[i].err});
    end

    // R7 status write clears error
    wr(2'd3, 32'h0);
    rd(2'd3, v); chk("R7", "status cleared", v, 32'h0);

    // R6 disabled: commands retire with no effect
    pk_enable = 1'b0;
    send(1'b0, 16'hFFFF, 5'd16);
    chk("R6", "no write", {31'b0, mem_wvalid}, 32'd0);
    send(1'b0, 16'h0000, 5'd0);
    send(1'b1, 16'h0000, 5'd0);
    chk("R6", "no write after flush", {31'b0, mem_wvalid}, 32'd0);
    rd(2'd2, v); chk("R6", "count kept", v, 32'd5);
    rd(2'd1, v); chk("R6", "partial kept", v, 32'h18000000);
    rd(2'd3, v); chk("R6", "no error", v, 32'h0);
    rd(2'd0, v); chk("R6", "address kept", v, 32'h10C);
    pk_enable = 1'b1;

    // R7 address write aligns and clears the count
    wr(2'd0, 32'h203);
    rd(2'd0, v); chk("R7", "aligned address", v, 32'h200);
    rd(2'd2, v); chk("R7", "count cleared", v, 32'h0);

    // R1 dirty low bits of a written partial word are not packed
    wr(2'd1, 32'hA5A5A5A5);
    wr(2'd2, 32'd4);
    send(1'b0, 16'h0005, 5'd4);
    rd(2'd1, v); chk("R1", "partial after dirty write", v, 32'hA5000000);
    rd(2'd2, v); chk("R1", "count after dirty write", v, 32'd8);
    send(1'b1, 16'h0000, 5'd0);
    chk("R4", "flush strobe", {31'b0, mem_wvalid}, 32'd1);
    chk("R4", "flush data", mem_wdata, 32'hA5FFFFFF);
    chk("R4", "flush addr", mem_waddr, 32'h200);
    rd(2'd0, v); chk("R2", "address advanced", v, 32'h204);

    // R8 register write holds off commands
    @(negedge clk);
    spr_we = 1'b1; spr_sel = 2'd3; spr_wdata = 32'h0;
    #1;
    chk("R8", "ready during reg write", {31'b0, cmd_ready}, 32'd0);
    @(negedge clk);
    spr_we = 1'b0;

    // R3 memory stall
    mem_wready = 1'b0;
    wr(2'd0, 32'h300);
    send(1'b0, 16'hFFFF, 5'd16);
    send(1'b0, 16'hFFFF, 5'd16);
    cmd_valid = 1'b1; cmd_flush = 1'b0; cmd_code = 16'h0003; cmd_len = 5'd2;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R3", "write held", {31'b0, mem_wvalid}, 32'd1);
      chk("R3", "addr held", mem_waddr, 32'h300);
      chk("R3", "data held", mem_wdata, 32'hFFFFFFFF);
      chk("R3", "stalled", {31'b0, cmd_ready}, 32'd0);
    end
    cmd_valid = 1'b0;
    rd(2'd2, v); chk("R3", "no code taken in stall", v, 32'd0);
    mem_wready = 1'b1;
    @(negedge clk);
    chk("R3", "write released", {31'b0, mem_wvalid}, 32'd0);
    send(1'b0, 16'h0003, 5'd2);
    rd(2'd2, v); chk("R3", "count after stall", v, 32'd2);
    rd(2'd1, v); chk("R3", "partial after stall", v, 32'hC0000000);
    rd(2'd0, v); chk("R3", "address after stall", v, 32'h304);

    done = 1'b1;
    finish_up();
  end

endmodule